// File: doc/BRIEF.md
# Auxiliary Packet Transmit Framer

This block turns a payload left by a host in a local transmit buffer into a framed byte stream for an auxiliary link. The host first checks that the busy flag is clear, writes the payload bytes at offsets counted from zero, then writes the payload length. It then writes a start command with bit 0 set. The framer sends the payload in address order. If the length is not a multiple of four, it adds zero bytes to reach the next multiple. It then adds a four-byte CRC-32 computed over the payload and that padding.

The outgoing stream is a byte-wide valid/ready interface with first-byte and last-byte markers. A byte moves only in a cycle where `tx_valid` and `tx_ready` are both high. While `tx_ready` is low, the framer holds the byte and its markers unchanged. Once a frame starts, `tx_valid` stays high until the last CRC byte has moved. The busy flag covers the whole frame, and while it is high the framer ignores all host writes.

The transmit buffer is sized as half of an auxiliary memory region. The other half is reserved for the receive side, which is not part of this block.

Top module: `aux_tx_framer`

## Requirements
- R1: After reset, `busy` is 0, `tx_valid` is 0 and no byte is offered.
- R2: A start write (`go_we` high with `go_wdata[0]` = 1) while idle raises `busy` and `tx_valid` in the next cycle, and the first byte carries `tx_first`. A start write with bit 0 = 0 has no effect.
- R3: The first `len` bytes of the frame are buffer bytes 0 to `len`-1, in ascending address order.
- R4: Zero bytes follow the payload until the byte count reaches a multiple of 4. A payload whose length is already a multiple of 4 gets no padding.
- R5: Four CRC bytes follow the padding. The CRC is the reflected CRC-32 with polynomial 0xEDB88320, starting value 0xFFFFFFFF and a final inversion, taken over the payload and the padding. Its most significant byte is sent first.
- R6: A frame holds exactly the padded length plus 4 bytes. `tx_first` is set only on byte 0 and `tx_last` only on the final CRC byte. A zero-length payload sends the 4 CRC bytes alone.
- R7: While `tx_valid` is high and `tx_ready` is low, the next cycle still offers the same byte. `tx_valid` never drops inside a frame.
- R8: `busy` stays 1 until the cycle in which the last CRC byte is accepted, and reads 0 in the cycle after.
- R9: A start write that arrives while busy is ignored, so no second frame follows.
- R10: Buffer writes and length writes made while busy are ignored. Resending without rewriting gives the same frame again.
- R11: A length written above the buffer capacity is clamped to the capacity.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| buf_we | input | 1 | Write strobe for a transmit buffer byte |
| buf_addr | input | ADDR_W | Buffer byte offset |
| buf_wdata | input | 8 | Buffer byte value |
| len_we | input | 1 | Write strobe for the payload length |
| len_wdata | input | 16 | Payload length in bytes |
| go_we | input | 1 | Write strobe for the start command |
| go_wdata | input | 8 | Start command; bit 0 = 1 requests a frame |
| busy | output | 1 | High from start until the last byte is accepted |
| tx_valid | output | 1 | An outgoing byte is offered |
| tx_ready | input | 1 | The sink accepts the offered byte |
| tx_data | output | 8 | Outgoing byte |
| tx_first | output | 1 | Marks the first byte of a frame |
| tx_last | output | 1 | Marks the final CRC byte |

## Verification
The checker assumes nothing about the sink: `tx_ready` may toggle in any pattern. It assumes a host that only starts a frame after writing the buffer and the length, since a start from idle always launches a frame, even one with stale data. The stimulus keeps buffer addresses inside the buffer. It uses both a steady-ready sink and a sink that stalls every third cycle. It deliberately writes to the buffer and the length, and sends start commands, while a frame is in flight, so that the ignore rules are exercised rather than assumed.

// File: rtl/aux_tx_pkg.sv
package aux_tx_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_BODY = 2'd1,
    ST_CRC  = 2'd2
  } fr_state_e;

  localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;
  localparam logic [31:0] CRC_SEED      = 32'hFFFF_FFFF;

  // One byte of the reflected CRC-32, least significant bit first.
  function automatic logic [31:0] crc_byte_step(input logic [31:0] c, input logic [7:0] b);
    logic [31:0] r;
    r = c ^ {24'd0, b};
    for (int i = 0; i < 8; i++) begin
      r = r[0] ? ((r >> 1) ^ CRC_POLY_REFL) : (r >> 1);
    end
    return r;
  endfunction

endpackage

// File: rtl/aux_tx_buf.sv
module aux_tx_buf #(
  parameter int DEPTH  = 64,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [7:0]        wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [7:0]        rdata
);
  logic [7:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  assign rdata = mem_q[raddr];
endmodule

// File: rtl/aux_tx_crc.sv
module aux_tx_crc
  import aux_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clear,
  input  logic        advance,
  input  logic [7:0]  din,
  output logic [31:0] crc_q
);
  always_ff @(posedge clk) begin
    if (!rst_n || clear) crc_q <= CRC_SEED;
    else if (advance)    crc_q <= crc_byte_step(crc_q, din);
  end
endmodule

// File: rtl/aux_tx_framer.sv
module aux_tx_framer
  import aux_tx_pkg::*;
#(
  parameter int AUX_BYTES = 128,
  parameter int BUF_BYTES = AUX_BYTES / 2,
  parameter int ADDR_W    = $clog2(BUF_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              buf_we,
  input  logic [ADDR_W-1:0] buf_addr,
  input  logic [7:0]        buf_wdata,
  input  logic              len_we,
  input  logic [15:0]       len_wdata,
  input  logic              go_we,
  input  logic [7:0]        go_wdata,
  output logic              busy,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_first,
  output logic              tx_last
);
  localparam int LEN_W = $clog2(BUF_BYTES + 4) + 1;
  localparam logic [LEN_W-1:0] CAP = LEN_W'(BUF_BYTES);

  fr_state_e        state_q;
  logic [LEN_W-1:0] len_q, idx_q, pad_len;
  logic [1:0]       cnt_q;
  logic [7:0]       rd_data, body_byte;
  logic [31:0]      crc_q, crc_fin;
  logic             start_ok, fire, idle;

  assign idle     = (state_q == ST_IDLE);
  assign start_ok = go_we && go_wdata[0] && idle;
  assign fire     = tx_valid && tx_ready;
  assign pad_len  = (len_q + LEN_W'(3)) & ~LEN_W'(3);

  aux_tx_buf #(.DEPTH(BUF_BYTES), .ADDR_W(ADDR_W)) u_buf (
    .clk   (clk),
    .we    (buf_we && idle),
    .waddr (buf_addr),
    .wdata (buf_wdata),
    .raddr (idx_q[ADDR_W-1:0]),
    .rdata (rd_data)
  );

  assign body_byte = (idx_q < len_q) ? rd_data : 8'h00;

  aux_tx_crc u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clear   (start_ok),
    .advance ((state_q == ST_BODY) && fire),
    .din     (body_byte),
    .crc_q   (crc_q)
  );

  assign crc_fin = ~crc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      len_q <= '0;
    end else if (len_we && idle) begin
      len_q <= (len_wdata > 16'(BUF_BYTES)) ? CAP : len_wdata[LEN_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_ok) begin
          idx_q   <= '0;
          cnt_q   <= '0;
          state_q <= (pad_len == '0) ? ST_CRC : ST_BODY;
        end
        ST_BODY: if (fire) begin
          idx_q <= idx_q + LEN_W'(1);
          if (idx_q == pad_len - LEN_W'(1)) state_q <= ST_CRC;
        end
        ST_CRC: if (fire) begin
          cnt_q <= cnt_q + 2'd1;
          if (cnt_q == 2'd3) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    tx_data = 8'h00;
    if (state_q == ST_BODY) begin
      tx_data = body_byte;
    end else if (state_q == ST_CRC) begin
      case (cnt_q)
        2'd0:    tx_data = crc_fin[31:24];
        2'd1:    tx_data = crc_fin[23:16];
        2'd2:    tx_data = crc_fin[15:8];
        default: tx_data = crc_fin[7:0];
      endcase
    end
  end

  assign busy     = !idle;
  assign tx_valid = !idle;
  assign tx_first = ((state_q == ST_BODY) && (idx_q == '0)) ||
                    ((state_q == ST_CRC) && (cnt_q == 2'd0) && (pad_len == '0));
  assign tx_last  = (state_q == ST_CRC) && (cnt_q == 2'd3);
endmodule

// File: rtl/aux_tx_framer_chk.sv
module aux_tx_framer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       go_we,
  input logic [7:0] go_wdata,
  input logic       busy,
  input logic       tx_valid,
  input logic       tx_ready,
  input logic [7:0] tx_data,
  input logic       tx_first,
  input logic       tx_last
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |=> !busy && !tx_valid);

  // R2
  start_raises_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (go_we && go_wdata[0] && !busy) |=> busy && tx_valid && tx_first);

  // R6
  markers_apart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_first && tx_last));

  // R7
  hold_on_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> tx_valid && $stable(tx_data) && $stable(tx_last) && $stable(tx_first));

  // R7
  valid_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(tx_valid && tx_ready && tx_last)) |=> tx_valid);

  // R8
  busy_drops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && tx_ready && tx_last) |=> !busy);

  // R9
  no_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(tx_valid && tx_ready && tx_last)) |=> !tx_first || $stable(tx_first));
endmodule

bind aux_tx_framer aux_tx_framer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .go_we    (go_we),
  .go_wdata (go_wdata),
  .busy     (busy),
  .tx_valid (tx_valid),
  .tx_ready (tx_ready),
  .tx_data  (tx_data),
  .tx_first (tx_first),
  .tx_last  (tx_last)
);

// File: tb/aux_tx_framer_bench.sv
`timescale 1ns/1ps
module aux_tx_framer_bench;
  localparam int BUF = 64;
  localparam int AW  = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic buf_we = 0, len_we = 0, go_we = 0, tx_ready = 0;
  logic [AW-1:0] buf_addr = '0;
  logic [7:0] buf_wdata = '0, go_wdata = '0;
  logic [15:0] len_wdata = '0;
  logic busy, tx_valid, tx_first, tx_last;
  logic [7:0] tx_data;

  always #2.5 clk = ~clk;

  aux_tx_framer u_aux_tx_framer (
    .clk(clk), .rst_n(rst_n), .buf_we(buf_we), .buf_addr(buf_addr), .buf_wdata(buf_wdata),
    .len_we(len_we), .len_wdata(len_wdata), .go_we(go_we), .go_wdata(go_wdata),
    .busy(busy), .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_first(tx_first), .tx_last(tx_last)
  );

  int n_chk = 0, n_bad = 0;
  logic [7:0] model [BUF];
  logic [7:0] exp_b [BUF + 8];
  int exp_n;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] ref_crc(input int n);
    logic [31:0] c;
    c = 32'hFFFF_FFFF;
    for (int k = 0; k < n; k++) begin
      for (int j = 0; j < 8; j++) begin
        logic fb;
        fb = c[0] ^ exp_b[k][j];
        c = c >> 1;
        if (fb) c = c ^ 32'hEDB88320;
      end
    end
    return ~c;
  endfunction

  task automatic build_expect(input int len);
    int l, p;
    logic [31:0] c;
    l = (len > BUF) ? BUF : len;
    p = (l + 3) / 4 * 4;
    for (int k = 0; k < p; k++) exp_b[k] = (k < l) ? model[k] : 8'h00;
    c = ref_crc(p);
    exp_b[p]   = c[31:24];
    exp_b[p+1] = c[23:16];
    exp_b[p+2] = c[15:8];
    exp_b[p+3] = c[7:0];
    exp_n = p + 4;
  endtask

  task automatic fill(input int n, input int seed);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      buf_we = 1; buf_addr = AW'(k); buf_wdata = 8'(seed * 7 + k * 13 + 1);
      model[k] = buf_wdata;
    end
    @(negedge clk);
    buf_we = 0;
  endtask

  // Writes length and start, collects the frame and compares it.
  task automatic frame(input int len, input bit stall, input bit disturb, input bool_dummy_unused = 0);
    int n, cyc, plen;
    logic [7:0] got [BUF + 8];
    logic gf [BUF + 8];
    logic gl [BUF + 8];
    bit done;
    plen = (((len > BUF) ? BUF : len) + 3) / 4 * 4;
    @(negedge clk); len_we = 1; len_wdata = 16'(len);
    @(negedge clk); len_we = 0; go_we = 1; go_wdata = 8'h01;
    @(negedge clk); go_we = 0;
    chk(busy === 1'b1, "R2 busy after start", busy, 1);
    chk(tx_valid === 1'b1 && tx_first === 1'b1, "R2 first byte offered", {tx_valid, tx_first}, 3);
    build_expect(len);
    n = 0; cyc = 0; done = 0;
    while (!done && n < BUF + 8) begin
      tx_ready = stall ? (cyc % 3 != 0) : 1'b1;
      buf_we = 0; len_we = 0; go_we = 0;
      if (disturb && cyc == 2) begin
        buf_we = 1; buf_addr = '0; buf_wdata = ~model[0];
        len_we = 1; len_wdata = 16'd3;
        go_we = 1; go_wdata = 8'h01;
      end
      #1;
      if (tx_valid && tx_ready) begin
        got[n] = tx_data; gf[n] = tx_first; gl[n] = tx_last;
        if (tx_last) done = 1;
        n++;
      end
      if (!tx_valid) done = 1;
      cyc++;
      @(negedge clk);
    end
    buf_we = 0; len_we = 0; go_we = 0; tx_ready = 0;
    chk(busy === 1'b0, "R8 busy clear after last", busy, 0);
    chk(n == exp_n, "R6 frame length", n, exp_n);
    for (int k = 0; k < n && k < exp_n; k++) begin
      if (k < ((len > BUF) ? BUF : len))
        chk(got[k] === exp_b[k], "R3 payload byte", got[k], exp_b[k]);
      else if (k < plen)
        chk(got[k] === 8'h00, "R4 pad byte", got[k], 0);
      else
        chk(got[k] === exp_b[k], "R5 crc byte", got[k], exp_b[k]);
      chk(gf[k] === (k == 0), "R6 first marker", gf[k], k == 0);
      chk(gl[k] === (k == exp_n - 1), "R6 last marker", gl[k], k == exp_n - 1);
    end
  endtask

  task automatic t_reset;
    chk(busy === 1'b0, "R1 busy at reset", busy, 0);
    chk(tx_valid === 1'b0, "R1 valid at reset", tx_valid, 0);
  endtask

  task automatic t_start_bit0_clear;
    @(negedge clk); go_we = 1; go_wdata = 8'hFE;
    @(negedge clk); go_we = 0;
    chk(busy === 1'b0 && tx_valid === 1'b0, "R2 start with bit0 clear", {busy, tx_valid}, 0);
  endtask

  task automatic t_restart_ignored;
    fill(6, 4);
    frame(6, 0, 1);
    repeat (5) @(negedge clk);
    chk(tx_valid === 1'b0 && busy === 1'b0, "R9 no second frame", {busy, tx_valid}, 0);
    // R10: buffer byte 0 and length unchanged, so resending repeats the frame
    @(negedge clk); go_we = 1; go_wdata = 8'h01;
    @(negedge clk); go_we = 0;
    begin
      int n;
      bit ok;
      n = 0; ok = 1;
      tx_ready = 1;
      while (tx_valid && n < BUF + 8) begin
        #1;
        if (tx_data !== exp_b[n]) ok = 0;
        n++;
        @(negedge clk);
      end
      tx_ready = 0;
      chk(ok && n == exp_n, "R10 writes during frame ignored", n, exp_n);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1 t_reset();
    rst_n = 1;
    t_start_bit0_clear();
    fill(8, 1);  frame(8, 0, 0);
    fill(5, 2);  frame(5, 0, 0);
    fill(1, 3);  frame(1, 1, 0);
    frame(0, 0, 0);
    fill(11, 5); frame(11, 1, 0);
    t_restart_ignored();
    fill(BUF, 6); frame(100, 1, 0);   // R11 clamp
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule